// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt lines into one request to a processor. Each line is fixed at build time as edge-sensitive or level-sensitive. A detected event is latched into a status vector. A mask of enable bits selects which latched events may raise the request. Software reaches the controller through a small word-addressed register port. Through that port it can load the mask directly, or set and clear individual mask bits without a read-modify-write. It clears latched events by writing ones, and it reads back a vector register. The vector register names the lowest-numbered line that is both latched and enabled.

A two-bit master control gates the request. The output is asserted only when both bits are one and at least one enabled event is latched. The output comes from a flop. An interrupt handler is expected to read the vector, service that line, clear it and read the vector again, until the vector reads all ones.

Top module: `vic_top`

## Requirements
- R1: After reset the status, the enable mask and the master control read as zero, the vector reads 0xFFFFFFFF and irq_o is low.
- R2: An edge-sensitive line (EDGE_MASK bit = 1) latches its status bit on a clock where it is high and was low at the previous clock. A line held high is not latched again after it has been cleared.
- R3: A level-sensitive line (EDGE_MASK bit = 0) latches its status bit on every clock where it is high. A clear issued while it is still high has no effect, and a clear issued after it falls does take effect.
- R4: Writing to the clear register (byte offset 0x0C) clears every status bit written as 1. Bits written as 0 are untouched, and 0xFFFFFFFF clears all of them.
- R5: The mask register (offset 0x08) is loaded with the written word, so writing 0 disables every line.
- R6: Writing to offset 0x10 sets each mask bit written as 1, and writing to offset 0x14 clears each mask bit written as 1. Zero bits leave the mask unchanged in both cases.
- R7: Offset 0x04 reads as status AND mask.
- R8: Offset 0x18 reads as the index of the lowest set bit of status AND mask, or 0xFFFFFFFF when none is set.
- R9: Offset 0x1C holds the master control in bits 1:0. At a clock edge, irq_o takes the value "both master bits are 1 and status AND mask is nonzero", evaluated on the state before that edge.
- R10: Writes to the status (0x00), status AND mask (0x04) and vector (0x18) offsets have no effect. Offsets 0x0C, 0x10 and 0x14 read as zero. Mask and status bits at or above NUM_SRC read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt lines, synchronous to clk_i |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset; bits 4:2 select the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset, combinational; zero when no read is in progress |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench goes after several specific mistakes:
- Holding an edge-sensitive line high across a clear. A design that latched on level instead of on the transition would show the bit again.
- Clearing a level line while it is still asserted. A design that let the clear win over the new event would lose a live request.
- Keeping several bits pending at once with only some of them enabled. A wrong priority order, or vector logic that ignores the mask, would report the wrong index.
- Setting the master bits one at a time and clearing with all ones. A design with only one master gate, or with a request output that is not registered, would show irq_o in the wrong cycle.

## Verification method
A behavioural model in the bench runs alongside the design and is compared with it on every clock, under both directed and random traffic.

// File: rtl/vic_pkg.sv
package vic_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned MAX_SRC = 32;

  // word index = byte offset >> 2; order fixed by software-visible map
  typedef enum logic [2:0] {
    RG_STAT  = 3'd0,
    RG_PEND  = 3'd1,
    RG_MASK  = 3'd2,
    RG_CLR   = 3'd3,
    RG_MSET  = 3'd4,
    RG_MCLR  = 3'd5,
    RG_VEC   = 3'd6,
    RG_MCTL  = 3'd7
  } reg_sel_e;

  localparam logic [BUS_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/vic_capture.sv
module vic_capture
  import vic_pkg::*;
#(
  parameter int unsigned N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N-1:0] hit;
  logic [N-1:0] status_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= src_i[g];
      end
      assign hit[g] = src_i[g] & ~prev_q;
    end else begin : g_lvl
      assign hit[g] = src_i[g];
    end
  end

  // new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit;
  end

  assign status_o = status_q;
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [N-1:0]     mask_o,
  output logic [1:0]       mctl_o,
  output logic [N-1:0]     clr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N-1:0] mask_q, mask_d;
  logic [1:0]   mctl_q;
  logic [N-1:0] wbits;

  assign wbits = wdata_i[N-1:0];

  always_comb begin
    mask_d = mask_q;
    if (wr_i) begin
      case (sel_i)
        RG_MASK: mask_d = wbits;
        RG_MSET: mask_d = mask_q | wbits;
        RG_MCLR: mask_d = mask_q & ~wbits;
        default: mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mctl_q <= 2'b00;
    end else begin
      mask_q <= mask_d;
      if (wr_i && sel_i == RG_MCTL) mctl_q <= wdata_i[1:0];
    end
  end

  assign clr_o  = (wr_i && sel_i == RG_CLR) ? wbits : '0;
  assign mask_o = mask_q;
  assign mctl_o = mctl_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // scan downwards so the lowest index is the last one to win
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [4:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e             sel;
  logic                 wr;
  logic [NUM_SRC-1:0]   clr, status, mask, pend;
  logic [1:0]           mctl;
  logic                 vec_any;
  logic [IDX_W-1:0]     vec_idx;
  logic                 irq_q;

  assign sel = reg_sel_e'(bus_addr_i[4:2]);
  assign wr  = bus_sel_i & bus_we_i;

  vic_regs #(.N(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .sel_i   (sel),
    .wdata_i (bus_wdata_i),
    .mask_o  (mask),
    .mctl_o  (mctl),
    .clr_o   (clr)
  );

  vic_capture #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .clr_i    (clr),
    .status_o (status)
  );

  assign pend = status & mask;

  vic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i (pend),
    .any_o  (vec_any),
    .idx_o  (vec_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (&mctl) & (|pend);
  end
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (sel)
        RG_STAT: bus_rdata_o[NUM_SRC-1:0] = status;
        RG_PEND: bus_rdata_o[NUM_SRC-1:0] = pend;
        RG_MASK: bus_rdata_o[NUM_SRC-1:0] = mask;
        RG_VEC: begin
          if (vec_any) bus_rdata_o[IDX_W-1:0] = vec_idx;
          else         bus_rdata_o = VEC_NONE;
        end
        RG_MCTL: bus_rdata_o[1:0] = mctl;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0,
  parameter int unsigned IDX_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     src_i,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [4:0]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [31:0]      bus_rdata_o,
  input logic             irq_o,
  input logic [N-1:0]     status_i,
  input logic [N-1:0]     mask_i,
  input logic [1:0]       mctl_i,
  input logic             vec_any_i,
  input logic [IDX_W-1:0] vec_idx_i
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [N-1:0] LVL_M = ~EDGE_MASK[N-1:0];

  logic [N-1:0] pend_c, below;
  logic         wr_c;
  logic [N-1:0] wbits;

  assign pend_c = status_i & mask_i;
  assign wr_c   = bus_sel_i & bus_we_i;
  assign wbits  = bus_wdata_i[N-1:0];

  always_comb begin
    below = '0;
    for (int i = 0; i < N; i++) if (i < int'(vec_idx_i)) below[i] = pend_c[i];
  end

  // R9
  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mctl_i == 2'b11 && pend_c != '0));
  // R9
  a_r9_irq_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mctl_i == 2'b11 && pend_c != '0) |-> irq_o);
  // R8
  a_r8_vec_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i[4:2] == 3'd6 && pend_c == '0)
      |-> bus_rdata_o == 32'hFFFF_FFFF);
  // R8
  a_r8_vec_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_any_i |-> (((pend_c >> vec_idx_i) & N'(1)) != '0) && below == '0);
  // R6
  a_r6_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && bus_addr_i[4:2] == 3'd4) |=> (mask_i & $past(wbits)) == $past(wbits));
  // R6
  a_r6_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && bus_addr_i[4:2] == 3'd5) |=> (mask_i & $past(wbits)) == '0);
  // R3
  a_r3_level_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & LVL_M) != '0) |=> (status_i & $past(src_i & LVL_M)) == $past(src_i & LVL_M));
  // R4
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && bus_addr_i[4:2] == 3'd3 && src_i == '0) |=> (status_i & $past(wbits)) == '0);
endmodule

bind vic_top vic_checker #(
  .N(NUM_SRC), .EDGE_MASK(EDGE_MASK), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .status_i    (status),
  .mask_i      (mask),
  .mctl_i      (mctl),
  .vec_any_i   (vec_any),
  .vec_idx_i   (vec_idx)
);

// File: tb/vic_top_test.sv
module vic_top_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned N = 12;
  localparam logic [31:0] EM = 32'hFFFF_F0A5; // lines 0,2,5,7 edge; rest level
  localparam logic [31:0] NMASK = (32'd1 << N) - 32'd1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] src = '0;
  logic sel = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #2.5 clk = ~clk;

  vic_top #(.NUM_SRC(N), .EDGE_MASK(EM)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
  logic [1:0]  m_me = '0;
  logic        m_irq = 1'b0;
  logic [31:0] last_rd;

  function automatic logic [31:0] m_vec();
    for (int i = 0; i < int'(N); i++) if (m_stat[i] && m_en[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(logic s, logic w, logic [4:0] a);
    if (!s || w) return 32'h0;
    case (a[4:2])
      3'd0: return m_stat;
      3'd1: return m_stat & m_en;
      3'd2: return m_en;
      3'd6: return m_vec();
      3'd7: return {30'h0, m_me};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a[4:2])
      3'd0: return "R3";
      3'd1: return "R7";
      3'd2: return "R5";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic m_step();
    logic [31:0] hit, clr;
    logic irq_n;
    irq_n = (m_me == 2'b11) && ((m_stat & m_en) != 0);
    hit = '0;
    for (int i = 0; i < int'(N); i++)
      hit[i] = EM[i] ? (src[i] && !m_prev[i]) : src[i];
    clr = (sel && we && addr[4:2] == 3'd3) ? wdata : 32'h0;
    for (int i = 0; i < int'(N); i++)
      if (hit[i]) m_stat[i] = 1'b1; else if (clr[i]) m_stat[i] = 1'b0;
    if (sel && we) begin
      case (addr[4:2])
        3'd2: m_en = wdata & NMASK;
        3'd4: m_en = (m_en | wdata) & NMASK;
        3'd5: m_en = m_en & ~wdata;
        3'd7: m_me = wdata[1:0];
        default: ;
      endcase
    end
    m_prev = 32'(src);
    m_irq = irq_n;
  endtask

  // drive at negedge, compare, advance one clock
  task automatic cyc(logic [N-1:0] s, logic sl, logic w, logic [4:0] a, logic [31:0] d);
    src = s; sel = sl; we = w; addr = a; wdata = d;
    #1;
    last_rd = rdata;
    chk(tag_of(a), rdata, m_read(sl, w, a));
    chk("R9", 32'(irq), 32'(m_irq));
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic rd(logic [N-1:0] s, logic [4:0] a);
    cyc(s, 1'b1, 1'b0, a, 32'h0);
  endtask

  task automatic wr(logic [N-1:0] s, logic [4:0] a, logic [31:0] d);
    cyc(s, 1'b1, 1'b1, a, d);
  endtask

  task automatic idle(logic [N-1:0] s);
    cyc(s, 1'b0, 1'b0, 5'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd('0, 5'h00); chk("R1", last_rd, 32'h0);
    rd('0, 5'h08); chk("R1", last_rd, 32'h0);
    rd('0, 5'h1C); chk("R1", last_rd, 32'h0);
    rd('0, 5'h18); chk("R1", last_rd, 32'hFFFF_FFFF);
    chk("R1", 32'(irq), 32'h0);

    // R2 edge line 2
    idle(12'h004);
    rd('0, 5'h00); chk("R2", last_rd, 32'h004);
    wr('0, 5'h0C, 32'h004);
    idle(12'h004); idle(12'h004); idle(12'h004);
    wr(12'h004, 5'h0C, 32'h004);
    rd(12'h004, 5'h00); chk("R2", last_rd, 32'h0);
    idle('0);

    // R3 level line 3
    idle(12'h008);
    wr(12'h008, 5'h0C, 32'h008);
    rd(12'h008, 5'h00); chk("R3", last_rd, 32'h008);
    wr('0, 5'h0C, 32'h008);
    rd('0, 5'h00); chk("R3", last_rd, 32'h0);

    // R5 / R6 / R10 mask
    wr('0, 5'h08, 32'hFFFF_FFFF);
    rd('0, 5'h08); chk("R10", last_rd, 32'h0000_0FFF);
    wr('0, 5'h08, 32'h0);
    rd('0, 5'h08); chk("R5", last_rd, 32'h0);
    wr('0, 5'h10, 32'h030);
    wr('0, 5'h10, 32'h001);
    rd('0, 5'h08); chk("R6", last_rd, 32'h031);
    wr('0, 5'h14, 32'h010);
    rd('0, 5'h08); chk("R6", last_rd, 32'h021);

    // R7 / R8 pending and vector
    idle(12'h022);
    rd('0, 5'h04); chk("R7", last_rd, 32'h020);
    rd('0, 5'h18); chk("R8", last_rd, 32'd5);
    wr('0, 5'h10, 32'h002);
    rd('0, 5'h18); chk("R8", last_rd, 32'd1);
    rd('0, 5'h04); chk("R7", last_rd, 32'h022);

    // R9 master gating and latency
    chk("R9", 32'(irq), 32'h0);
    wr('0, 5'h1C, 32'h1);
    idle('0);
    chk("R9", 32'(irq), 32'h0);
    wr('0, 5'h1C, 32'h3);
    chk("R9", 32'(irq), 32'h0);
    idle('0);
    chk("R9", 32'(irq), 32'h1);
    rd('0, 5'h1C); chk("R9", last_rd, 32'h3);

    // R10 read-only and write-only offsets
    wr('0, 5'h00, 32'h0);
    wr('0, 5'h04, 32'h0);
    wr('0, 5'h18, 32'h0);
    rd('0, 5'h00); chk("R10", last_rd, 32'h022);
    rd('0, 5'h0C); chk("R10", last_rd, 32'h0);
    rd('0, 5'h10); chk("R10", last_rd, 32'h0);
    rd('0, 5'h14); chk("R10", last_rd, 32'h0);

    // R4 partial, zero and full clear
    wr('0, 5'h0C, 32'h020);
    rd('0, 5'h00); chk("R4", last_rd, 32'h002);
    wr('0, 5'h0C, 32'h0);
    rd('0, 5'h00); chk("R4", last_rd, 32'h002);
    wr('0, 5'h0C, 32'hFFFF_FFFF);
    chk("R9", 32'(irq), 32'h1);
    rd('0, 5'h00); chk("R4", last_rd, 32'h0);
    chk("R9", 32'(irq), 32'h0);
    rd('0, 5'h18); chk("R8", last_rd, 32'hFFFF_FFFF);

    // random traffic against the model
    for (int k = 0; k < 6000; k++) begin
      logic [N-1:0] s;
      logic [31:0] d;
      s = N'($urandom) & N'($urandom);
      d = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc(s, 1'($urandom_range(0, 3) != 0), 1'($urandom), 5'($urandom_range(0, 7) << 2), d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule